// File: doc/BRIEF.md
# Six-Pin GPIO Ownership Multiplexer

This block sits between six bidirectional general-purpose pads and the logic that wants to drive them. Every pad is controlled by a data bit and an output-enable bit. The twelve control bits for all six pads come from one of four owners. The first owner is a control word written by software. The other three are peripheral channels A, B and C. A two-bit owner field in the same control word picks the owner. The choice can be changed at run time, so a peripheral can take over the pads and later hand them back to software.

The pad outputs and enables come straight from flops, so a change of owner does not put a combinational glitch on any pad. The incoming pad levels pass through a two-flop synchronizer. The synchronized word is the software readback value, and the same word is also fanned out to the peripheral channels. The readback bit order is fixed: bit 0 is the serial clock pin, bit 1 serial data, bit 2 reset, bit 3 auxiliary clock, bit 4 exposure and bit 5 trigger.

Ownership is held in a small state machine with four states: `OWN_SW`, `OWN_A`, `OWN_B` and `OWN_C`. A control-word write takes the transition to the state that the owner field encodes. This happens from every state, including a write that keeps the current state. With no write, every state loops on itself. Reset enters `OWN_SW`.

Top module: `pin_owner_mux`

## Requirements
- R1: Pad n (0..5) takes its data level from bit 2n and its output enable from bit 2n+1 of the 12-bit control vector of the current owner.
- R2: During and right after reset, the owner is software and the stored control bits are all zero. So pad_oe, pad_out and pin_level are all zero.
- R3: With owner 0 (software), the pads follow cfg_wdata[11:0] of the last write. A write sampled on clock edge E shows on the pads after edge E+1.
- R4: With owner 1, 2 or 3, the pads follow cha_ctl, chb_ctl or chc_ctl. A channel value present at edge E shows on the pads after edge E.
- R5: The owner field is cfg_wdata[13:12] of a write, with 0 = software, 1 = A, 2 = B and 3 = C. A write at edge E switches the owner at E, and the pads carry the new owner's bits after edge E+1.
- R6: Channels that do not own the pads, and the stored software bits while a channel owns them, have no effect on pad_out or pad_oe.
- R7: pin_level equals pad_in delayed by two clock edges. The readback bit order is 0 serial clock, 1 serial data, 2 reset, 3 auxiliary clock, 4 exposure, 5 trigger.
- R8: chan_pin_in carries the same synchronized pad levels as pin_level, for all three channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 14 | Control word: [13:12] owner, [11:0] software pad controls |
| cha_ctl | input | 12 | Pad control vector of channel A |
| chb_ctl | input | 12 | Pad control vector of channel B |
| chc_ctl | input | 12 | Pad control vector of channel C |
| pad_in | input | 6 | Raw pad levels |
| pad_out | output | 6 | Registered pad data levels |
| pad_oe | output | 6 | Registered pad output enables |
| pin_level | output | 6 | Synchronized pad levels for software readback |
| chan_pin_in | output | 6 | Synchronized pad levels forwarded to the channels |

## Verification
The bench checks the two-edge latency of an owner change. A design that applied the new owner a cycle early or late would show the old or new vector one cycle off. Activity on idle channels is randomized while another owner holds the pads, so a mux with a wrong select decode would leak a foreign vector onto the pads. The bench also checks the data/enable bit pairing per pad, where a swapped pair would drive levels onto pads that should float. Finally it checks the exact two-edge delay of the input readback, which a missing or extra synchronizer stage would break.

// File: rtl/pom_pkg.sv
package pom_pkg;
    typedef enum logic [1:0] {
        OWN_SW = 2'd0,
        OWN_A  = 2'd1,
        OWN_B  = 2'd2,
        OWN_C  = 2'd3
    } owner_e;

    localparam int unsigned OWNER_W = 2;
endpackage

// File: rtl/pom_sync.sv
module pom_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pom_owner_fsm.sv
module pom_owner_fsm
    import pom_pkg::*;
#(
    parameter int unsigned CTL_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [CTL_W+OWNER_W-1:0] wdata,
    output owner_e                   owner,
    output logic [CTL_W-1:0]         sw_ctl
);
    localparam int unsigned SEL_LO = CTL_W;
    localparam int unsigned SEL_HI = CTL_W + OWNER_W - 1;

    owner_e           state_q, state_d;
    logic [CTL_W-1:0] sw_q;

    // next-state logic: a write moves to the encoded owner, otherwise hold
    always_comb begin
        state_d = state_q;
        if (wr) begin
            unique case (wdata[SEL_HI:SEL_LO])
                2'd0: state_d = OWN_SW;
                2'd1: state_d = OWN_A;
                2'd2: state_d = OWN_B;
                2'd3: state_d = OWN_C;
                default: state_d = OWN_SW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OWN_SW;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sw_q <= '0;
        else if (wr) sw_q <= wdata[CTL_W-1:0];
    end

    assign owner  = state_q;
    assign sw_ctl = sw_q;

    // R5: the owner field of a write becomes the owner one edge later
    a_r5_owner_update: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (2'(owner) == $past(wdata[SEL_HI:SEL_LO])));

    // R5: without a write, the owner holds
    a_r5_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(owner));
endmodule

// File: rtl/pom_drive.sv
module pom_drive
    import pom_pkg::*;
#(
    parameter int unsigned NPINS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  owner_e             owner,
    input  logic [2*NPINS-1:0] sw_ctl,
    input  logic [2*NPINS-1:0] cha_ctl,
    input  logic [2*NPINS-1:0] chb_ctl,
    input  logic [2*NPINS-1:0] chc_ctl,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe
);
    localparam int unsigned CTL_W = 2 * NPINS;

    logic [CTL_W-1:0] src_ctl;
    logic [NPINS-1:0] out_q, oe_q;
    logic [NPINS-1:0] a_dat, a_en, sw_dat, sw_en;

    // output-side select driven by the owner state
    always_comb begin
        unique case (owner)
            OWN_SW:  src_ctl = sw_ctl;
            OWN_A:   src_ctl = cha_ctl;
            OWN_B:   src_ctl = chb_ctl;
            OWN_C:   src_ctl = chc_ctl;
            default: src_ctl = sw_ctl;
        endcase
    end

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q[n] <= 1'b0;
                oe_q[n]  <= 1'b0;
            end else begin
                out_q[n] <= src_ctl[2*n];
                oe_q[n]  <= src_ctl[2*n+1];
            end
        end
        assign sw_dat[n] = sw_ctl[2*n];
        assign sw_en[n]  = sw_ctl[2*n+1];
        assign a_dat[n]  = cha_ctl[2*n];
        assign a_en[n]   = cha_ctl[2*n+1];
    end

    assign pad_out = out_q;
    assign pad_oe  = oe_q;

    // R3: software owner -> pads take the stored software bits on the next edge
    a_r3_sw_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_SW) |=> (pad_out == $past(sw_dat) && pad_oe == $past(sw_en)));

    // R4: channel A owner -> pads take channel A bits on the next edge
    a_r4_cha_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_A) |=> (pad_out == $past(a_dat) && pad_oe == $past(a_en)));
endmodule

// File: rtl/pin_owner_mux.sv
module pin_owner_mux
    import pom_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [2*NUM_PINS+1:0]     cfg_wdata,
    input  logic [2*NUM_PINS-1:0]     cha_ctl,
    input  logic [2*NUM_PINS-1:0]     chb_ctl,
    input  logic [2*NUM_PINS-1:0]     chc_ctl,
    input  logic [NUM_PINS-1:0]       pad_in,
    output logic [NUM_PINS-1:0]       pad_out,
    output logic [NUM_PINS-1:0]       pad_oe,
    output logic [NUM_PINS-1:0]       pin_level,
    output logic [NUM_PINS-1:0]       chan_pin_in
);
    localparam int unsigned CTL_W = 2 * NUM_PINS;

    owner_e           owner;
    logic [CTL_W-1:0] sw_ctl;
    logic [NUM_PINS-1:0] level_sync;

    pom_owner_fsm #(.CTL_W(CTL_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wdata  (cfg_wdata),
        .owner  (owner),
        .sw_ctl (sw_ctl)
    );

    pom_drive #(.NPINS(NUM_PINS)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .owner   (owner),
        .sw_ctl  (sw_ctl),
        .cha_ctl (cha_ctl),
        .chb_ctl (chb_ctl),
        .chc_ctl (chc_ctl),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    pom_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (level_sync)
    );

    assign pin_level   = level_sync;
    assign chan_pin_in = level_sync;

    // R2: while reset is held, no pad is driven
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r2_reset_float: assert (pad_oe == '0 && pad_out == '0);
        end
    end

    if (SYNC_STAGES == 2) begin : g_lvl_chk
        // R7: readback is the pad level from two edges earlier
        a_r7_level_delay: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n, 2) |-> (pin_level == $past(pad_in, 2)));
    end
endmodule

// File: tb/tb_pin_owner_mux.sv
`timescale 1ns/1ps
module tb_pin_owner_mux;
    localparam int NP = 6;
    localparam int CW = 2 * NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [CW+1:0] cfg_wdata = '0;
    logic [CW-1:0] cha_ctl = '0, chb_ctl = '0, chc_ctl = '0;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pin_level, chan_pin_in;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state
    logic [1:0]    m_owner = 2'd0;
    logic [CW-1:0] m_sw = '0;
    logic [NP-1:0] prev_pin = '0;
    bit            prev_wr = 0;

    always #4 clk = ~clk;

    pin_owner_mux dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cha_ctl(cha_ctl), .chb_ctl(chb_ctl), .chc_ctl(chc_ctl),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pin_level(pin_level), .chan_pin_in(chan_pin_in)
    );

    function automatic logic [CW-1:0] pick_src(input logic [1:0] own, input logic [CW-1:0] sw,
                                               input logic [CW-1:0] a, input logic [CW-1:0] b,
                                               input logic [CW-1:0] c);
        case (own)
            2'd0: return sw;
            2'd1: return a;
            2'd2: return b;
            default: return c;
        endcase
    endfunction

    // split into {oe, out}: pad n data = bit 2n, enable = bit 2n+1
    function automatic logic [2*NP-1:0] split_pads(input logic [CW-1:0] v);
        logic [NP-1:0] o, e;
        for (int n = 0; n < NP; n++) begin
            o[n] = v[2*n];
            e[n] = v[2*n+1];
        end
        return {e, o};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: inputs driven at negedge, results checked at next negedge
    task automatic cycle(input bit wr, input logic [CW+1:0] wd, input logic [CW-1:0] a,
                         input logic [CW-1:0] b, input logic [CW-1:0] c, input logic [NP-1:0] pin);
        logic [CW-1:0] exp_src;
        logic [1:0]    own_used;
        cfg_wr = wr; cfg_wdata = wd; cha_ctl = a; chb_ctl = b; chc_ctl = c; pad_in = pin;
        own_used = m_owner;
        exp_src = pick_src(m_owner, m_sw, a, b, c);
        if (wr) begin
            m_owner = wd[CW+1:CW];
            m_sw    = wd[CW-1:0];
        end
        @(negedge clk);
        if (prev_wr)
            chk("R5 owner switch latency", 32'({pad_oe, pad_out}), 32'(split_pads(exp_src)));
        else if (own_used == 2'd0)
            chk("R1,R3 software drive", 32'({pad_oe, pad_out}), 32'(split_pads(exp_src)));
        else
            chk("R1,R4,R6 channel drive", 32'({pad_oe, pad_out}), 32'(split_pads(exp_src)));
        chk("R7 readback delay", 32'(pin_level), 32'(prev_pin));
        chk("R8 channel forward", 32'(chan_pin_in), 32'(prev_pin));
        prev_pin = pin;
        prev_wr = wr;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 reset oe", 32'(pad_oe), 32'h0);
        chk("R2 reset out", 32'(pad_out), 32'h0);
        chk("R2 reset level", 32'(pin_level), 32'h0);
        rst_n = 1'b1;

        // directed: software pattern, pad 0 data / pad 0 enable pairing
        cycle(1, 14'h0001, '0, '0, '0, 6'h01);
        cycle(0, '0, 12'hFFF, 12'hFFF, 12'hFFF, 6'h3E);
        chk("R1 pad0 data only", 32'({pad_oe, pad_out}), 32'({6'h00, 6'h01}));
        cycle(1, 14'h0002, '0, '0, '0, 6'h00);
        cycle(0, '0, '0, '0, '0, 6'h00);
        chk("R1 pad0 enable only", 32'({pad_oe, pad_out}), 32'({6'h01, 6'h00}));
        // R5/R6: hand over to B, then A and C toggle while B owns
        cycle(1, {2'd2, 12'hAAA}, 12'h123, 12'h5C3, 12'h777, 6'h15);
        cycle(0, '0, 12'h456, 12'h5C3, 12'h888, 6'h2A);
        cycle(0, '0, 12'hFFF, 12'h5C3, 12'h000, 6'h2A);
        chk("R6 idle channels ignored", 32'({pad_oe, pad_out}), 32'(split_pads(12'h5C3)));
        // corner: owner C, then back to software
        cycle(1, {2'd3, 12'h0F0}, '0, '0, 12'hC3C, 6'h00);
        cycle(0, '0, '0, '0, 12'hC3C, 6'h00);
        cycle(1, {2'd0, 12'h0F0}, '0, '0, 12'h3C3, 6'h3F);
        cycle(0, '0, '0, '0, 12'h3C3, 6'h3F);
        chk("R3 back to software", 32'({pad_oe, pad_out}), 32'(split_pads(12'h0F0)));

        // constrained random
        for (int i = 0; i < 600; i++) begin
            cycle(($urandom % 6) == 0, 14'($urandom), 12'($urandom), 12'($urandom),
                  12'($urandom), 6'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule